// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block is the load front end of a banked scratchpad. A group of lanes issues one load together: each lane supplies a byte address, and a mask says which lanes take part. The block finds the bank behind each address and which word inside that bank is wanted. Lanes that want the same word share a single bank read, and that value is copied to all of them. Lanes that want different words of the same bank are served over successive cycles.

When every active lane has its data, the block raises a one-cycle done pulse with all lane results valid. It then accepts the next issue. Issues never overlap.

The bank contents live in an internal register array that is filled with a fixed pattern at reset. Each bank returns one 32-bit word per cycle.

Top module: `scp_conflict_resolver`

## Requirements
- R1: After reset, in_ready is 1, out_done is 0 and out_data is all zero.
- R2: For a lane's byte address A, the word index is W = A >> 2. The bank is W mod NUM_BANKS and the row is W / NUM_BANKS. The two lowest address bits are ignored.
- R3: Word index W holds the value {~W[15:0], W[15:0]}. At done, every active lane's 32-bit slice of out_data (lane l at bits [32*l +: 32]) equals the word its address selects.
- R4: An issue in which every active lane maps to a different bank finishes in one service cycle.
- R5: N active lanes that read N distinct words of one bank take N service cycles.
- R6: Active lanes that read the same word are served by one bank read, for the whole group or for any subset, and add no cycles.
- R7: The number of service cycles is the largest count, over all banks, of distinct words requested in that bank, with a minimum of one. An issue with an all-zero mask takes one cycle. Inactive lanes never add cycles.
- R8: An issue is accepted on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 from then until done. in_valid and in_addr presented meanwhile are ignored.
- R9: out_done is high for exactly one cycle, N clock edges after the accepting edge, where N is the service-cycle count. Inactive lanes' out_data slices read zero.
- R10: On each service cycle, each bank reads the word of its lowest-numbered pending lane. Every pending lane asking for that word is satisfied in the same cycle, so each service cycle retires at least one lane.
- R11: Issues are handled strictly one after another. in_ready is 1 in the done cycle, so a new issue can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request present |
| in_ready | output | 1 | Block idle, issue can be taken |
| in_mask | input | NUM_LANES | Active lanes of the issue |
| in_addr | input | NUM_LANES*ADDR_W | Per-lane byte address, lane l at [l*ADDR_W +: ADDR_W] |
| out_done | output | 1 | One-cycle pulse, all lane data valid |
| out_data | output | NUM_LANES*32 | Per-lane load result, lane l at [32*l +: 32] |

## Verification
The assertions watch the service loop on every cycle:
- each bank grants at most one lane;
- each service cycle with pending lanes retires at least one lane, and no lane becomes pending again;
- no issue runs longer than the lane count;
- done is a single-cycle pulse that arrives with nothing pending and the block ready.

Only the bench's scenarios can show that the cycle count equals the per-bank maximum of distinct words, that broadcast subsets cost nothing, and that the data returned matches the addressed word. The bench compares both against its own reference model for conflict-free, fully conflicting, broadcast, masked, empty and pseudo-random issues, and while in_valid is held during a busy period.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
  localparam int WORD_BITS = 32;

  typedef enum logic {ST_IDLE = 1'b0, ST_SERVE = 1'b1} scp_state_e;

  // Fixed content of word index w after reset
  function automatic logic [WORD_BITS-1:0] init_word(input logic [31:0] w);
    return {~w[15:0], w[15:0]};
  endfunction
endpackage

// File: rtl/scp_bank_arbiter.sv
`timescale 1ns/1ps
// Picks, for one bank, the lowest-numbered pending lane that targets it.
module scp_bank_arbiter #(
  parameter int NUM_LANES = 32,
  parameter int WORD_W    = 10,
  parameter int BANK_W    = 5,
  parameter int BANK_ID   = 0
) (
  input  logic [NUM_LANES-1:0]        pending,
  input  logic [NUM_LANES*WORD_W-1:0] lane_word,
  output logic                        sel_valid,
  output logic [WORD_W-1:0]           sel_word,
  output logic [NUM_LANES-1:0]        grant
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  always_comb begin
    logic [WORD_W-1:0] cand;
    sel_valid = 1'b0;
    sel_word  = '0;
    grant     = '0;
    cand      = '0;
    // Walk from the top so the lowest matching lane wins last
    for (int l = NUM_LANES - 1; l >= 0; l--) begin
      cand = lane_word[l*WORD_W +: WORD_W];
      if (pending[l] && (cand[BANK_W-1:0] == MY_BANK)) begin
        sel_valid = 1'b1;
        sel_word  = cand;
        grant     = '0;
        grant[l]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scp_bank_store.sv
`timescale 1ns/1ps
// One bank: register rows filled at reset, one asynchronous read port.
module scp_bank_store #(
  parameter int NUM_BANKS = 32,
  parameter int ROWS      = 32,
  parameter int ROW_W     = 5,
  parameter int BANK_ID   = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ROW_W-1:0]               rd_row,
  output logic [scp_pkg::WORD_BITS-1:0]  rd_data
);
  logic [scp_pkg::WORD_BITS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        mem[r] <= scp_pkg::init_word(32'(r * NUM_BANKS + BANK_ID));
    end
  end

  assign rd_data = mem[rd_row];
endmodule

// File: rtl/scp_conflict_resolver.sv
`timescale 1ns/1ps
module scp_conflict_resolver #(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int BANK_ROWS = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(BANK_ROWS),
  localparam int WORD_W   = BANK_W + ROW_W,
  localparam int ADDR_W   = WORD_W + 2,
  localparam int DW       = scp_pkg::WORD_BITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_LANES-1:0]        in_mask,
  input  logic [NUM_LANES*ADDR_W-1:0] in_addr,
  output logic                        out_done,
  output logic [NUM_LANES*DW-1:0]     out_data
);
  import scp_pkg::*;

  localparam int CNT_W = $clog2(NUM_LANES + 1);

  scp_state_e                  state_q;
  logic [NUM_LANES-1:0]        pending_q;
  logic [NUM_LANES*WORD_W-1:0] lane_word_q;
  logic [NUM_LANES*DW-1:0]     data_q;
  logic                        done_q;
  logic [CNT_W-1:0]            svc_cnt_q;

  // Named internal events
  logic                  accept;
  logic                  serving;
  logic [NUM_LANES-1:0]  served;
  logic [NUM_LANES-1:0]  pending_next;
  logic                  last_service;

  logic [NUM_BANKS-1:0]  sel_valid;
  logic [WORD_W-1:0]     sel_word [NUM_BANKS];
  logic [NUM_LANES-1:0]  grant    [NUM_BANKS];
  logic [DW-1:0]         bank_rd  [NUM_BANKS];
  logic [DW-1:0]         lane_rd  [NUM_LANES];

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign serving  = (state_q == ST_SERVE);
  assign out_done = done_q;
  assign out_data = data_q;

  // Word index of a byte address: the low two bits are dropped
  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [WORD_W-1:0] w);
    return w[BANK_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BANK_W];
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    scp_bank_arbiter #(
      .NUM_LANES(NUM_LANES), .WORD_W(WORD_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) arb_i (
      .pending  (pending_q),
      .lane_word(lane_word_q),
      .sel_valid(sel_valid[b]),
      .sel_word (sel_word[b]),
      .grant    (grant[b])
    );

    scp_bank_store #(
      .NUM_BANKS(NUM_BANKS), .ROWS(BANK_ROWS), .ROW_W(ROW_W), .BANK_ID(b)
    ) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_row (row_of(sel_word[b])),
      .rd_data(bank_rd[b])
    );

    // R10: one lane at most is granted per bank and cycle
    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[b]));
  end

  // Every pending lane matching its bank's chosen word is satisfied
  always_comb begin
    logic [WORD_W-1:0] lw;
    logic [BANK_W-1:0] lb;
    lw = '0;
    lb = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      lw = lane_word_q[l*WORD_W +: WORD_W];
      lb = bank_of(lw);
      served[l]  = pending_q[l] && sel_valid[lb] && (sel_word[lb] == lw);
      lane_rd[l] = bank_rd[lb];
    end
  end

  assign pending_next = pending_q & ~served;
  assign last_service = serving && (pending_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pending_q   <= '0;
      lane_word_q <= '0;
      data_q      <= '0;
      done_q      <= 1'b0;
      svc_cnt_q   <= '0;
    end else if (accept) begin
      for (int l = 0; l < NUM_LANES; l++)
        lane_word_q[l*WORD_W +: WORD_W] <= word_of(in_addr[l*ADDR_W +: ADDR_W]);
      pending_q <= in_mask;
      data_q    <= '0;
      done_q    <= 1'b0;
      svc_cnt_q <= '0;
      state_q   <= ST_SERVE;
    end else if (serving) begin
      for (int l = 0; l < NUM_LANES; l++)
        if (served[l]) data_q[l*DW +: DW] <= lane_rd[l];
      pending_q <= pending_next;
      svc_cnt_q <= svc_cnt_q + 1'b1;
      done_q    <= last_service;
      if (last_service) state_q <= ST_IDLE;
    end else begin
      done_q <= 1'b0;
    end
  end

  // R10: a service cycle with work left retires at least one lane
  a_r10_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && pending_q != '0) |-> (served != '0));

  // R8: no lane becomes pending again while an issue is served
  a_r8_no_regrow: assert property (@(posedge clk) disable iff (!rst_n)
    serving |=> ((pending_q & ~$past(pending_q)) == '0));

  // R7: an issue never needs more service cycles than there are lanes
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> (svc_cnt_q < CNT_W'(NUM_LANES)));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R11: done arrives with nothing pending and the block ready
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (in_ready && pending_q == '0));
endmodule

// File: tb/scp_conflict_resolver_tb_top.sv
`timescale 1ns/1ps
module scp_conflict_resolver_tb_top;
  localparam int L  = 8;
  localparam int B  = 8;
  localparam int RW = 8;
  localparam int WW = $clog2(B) + $clog2(RW);
  localparam int AW = WW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [L-1:0]  in_mask = '0;
  logic [L*AW-1:0] in_addr = '0;
  logic          out_done;
  logic [L*32-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scp_conflict_resolver #(.NUM_LANES(L), .NUM_BANKS(B), .BANK_ROWS(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr), .out_done(out_done), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference: value stored at a word index
  function automatic logic [31:0] ref_word(input int w);
    logic [15:0] lo;
    lo = 16'(w);
    return {~lo, lo};
  endfunction

  function automatic int word_idx(input logic [L*AW-1:0] a, input int l);
    return int'(a[l*AW+2 +: WW]);
  endfunction

  // Reference: maximum over banks of distinct words, at least one
  function automatic int ref_cycles(input logic [L*AW-1:0] a, input logic [L-1:0] m);
    int best;
    best = 1;
    for (int b = 0; b < B; b++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < L; l++) begin
        bit fresh;
        fresh = m[l] && ((word_idx(a, l) % B) == b);
        for (int j = 0; j < l; j++)
          if (m[j] && word_idx(a, j) == word_idx(a, l)) fresh = 1'b0;
        if (fresh) cnt++;
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  function automatic logic [AW-1:0] mk(input int w, input int lowbits);
    return AW'(w * 4 + lowbits);
  endfunction

  // Issue one request, count service cycles, compare timing and data
  task automatic run_issue(input logic [L*AW-1:0] a, input logic [L-1:0] m,
                           input string req, input bit hold_valid);
    int cnt;
    int exp_cnt;
    exp_cnt = ref_cycles(a, m);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_mask = m;
    @(posedge clk);
    @(negedge clk);
    if (hold_valid) begin
      in_addr = ~a; in_mask = '1;     // R8: must be ignored while busy
    end else begin
      in_valid = 1'b0;
    end
    cnt = 0;
    for (int k = 0; k < 4 * L; k++) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (out_done) break;
      check(in_ready == 1'b0, "R8 ready low while busy", in_ready, 0);
    end
    in_valid = 1'b0;
    check(out_done == 1'b1, {req, " done seen"}, out_done, 1);
    check(cnt == exp_cnt, {req, " R7 cycle count"}, cnt, exp_cnt);
    check(in_ready == 1'b1, "R11 ready in done cycle", in_ready, 1);
    for (int l = 0; l < L; l++) begin
      logic [31:0] e;
      e = m[l] ? ref_word(word_idx(a, l)) : 32'h0;
      check(out_data[32*l +: 32] == e, {req, " R3/R9 lane data"}, out_data[32*l +: 32], e);
    end
    @(negedge clk);
    check(out_done == 1'b0, "R9 done one cycle", out_done, 0);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(out_done == 1'b0, "R1 done after reset", out_done, 0);
    check(out_data == '0, "R1 data after reset", 0, 0);
  endtask

  task automatic t_conflict_free();
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++)
      a[l*AW +: AW] = mk(((l * 3) % B) + B * (l % RW), l % 4); // R2 low bits ignored
    run_issue(a, '1, "R4 distinct banks", 1'b0);
  endtask

  task automatic t_full_conflict(input bit hold);
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++) a[l*AW +: AW] = mk(B * l + 5, 0);
    run_issue(a, '1, hold ? "R8 busy input ignored" : "R5 one bank all words", hold);
  endtask

  task automatic t_broadcast();
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++) a[l*AW +: AW] = mk(13, l % 4);
    run_issue(a, '1, "R6 full broadcast", 1'b0);
  endtask

  task automatic t_subsets();
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++)
      a[l*AW +: AW] = mk((l % 2 == 0) ? 9 : ((l % 3 == 0) ? 17 : 2 + l), 0);
    run_issue(a, '1, "R6 subset broadcast", 1'b0);
  endtask

  task automatic t_empty();
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++) a[l*AW +: AW] = mk(B * l, 0);
    run_issue(a, '0, "R7 empty mask", 1'b0);
  endtask

  task automatic t_masked();
    logic [L*AW-1:0] a;
    for (int l = 0; l < L; l++) a[l*AW +: AW] = mk(B * l + 2, 0);
    run_issue(a, 8'b0001_0001, "R7 masked conflict", 1'b0);
  endtask

  task automatic t_random();
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2024;
    for (int n = 0; n < 24; n++) begin
      logic [L*AW-1:0] a;
      logic [L-1:0] m;
      for (int l = 0; l < L; l++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a[l*AW +: AW] = AW'(lfsr[AW-1:0] & ((n % 3 == 0) ? {AW{1'b1}} : AW'(8'h3B)));
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m = (n % 4 == 0) ? '1 : lfsr[L-1:0];
      run_issue(a, m, "R10 pseudo-random", 1'b0);
    end
  endtask

  initial begin : watchdog
    #500000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conflict_free();
    t_full_conflict(1'b0);
    t_broadcast();
    t_subsets();
    t_empty();
    t_masked();
    t_full_conflict(1'b1);
    t_random();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule